// File: doc/BRIEF.md
# Tag-Matching Reservation Station Array

This block holds a few instructions that are waiting for one functional-unit type in an out-of-order core. The front end writes one instruction at a time: an opcode, a destination reorder-buffer tag and two source operands. Each source carries a readiness flag. With the flag set, the source field is the operand value. With the flag clear, its low bits name the reorder-buffer tag of the instruction that will produce the value.

A single result broadcast bus, carrying a tag and a value, is snooped by every occupied entry. Each waiting operand compares its tag against the broadcast. On a match it takes the value and marks itself ready. An entry whose two operands are both ready requests issue. A fixed-priority selector grants the lowest-numbered requester, and its fields drive the issue port in the same cycle. The unit is assumed to accept every issue, so the granted entry is freed at the following clock edge.

New instructions go into the lowest-numbered free entry. When every entry is occupied the block raises a full indication and drops any allocation. A flush input empties the whole array in one cycle.

Top module: `rs_station`

## Requirements
- R1: While reset (active-low, synchronous) is held, and at the first edge after it, `full` and `issue_valid` read 0.
- R2: An instruction allocated with both sources flagged ready drives `issue_valid`=1 with its opcode, both values and destination tag in the cycle after the allocation edge.
- R3: An entry with at least one source whose flag is clear never drives `issue_valid`.
- R4: A broadcast whose tag equals the tag held by a waiting operand stores the broadcast value in that operand and marks it ready at the same edge, in every matching entry at once. A non-matching tag changes nothing.
- R5: A source allocated with its flag clear, in the same cycle as a broadcast of its tag, captures the broadcast value and is ready from that edge.
- R6: When several entries are ready, the lowest-numbered one is issued, one per cycle.
- R7: A new instruction is placed in the lowest-numbered free entry. `full` is 1 exactly when every entry is occupied, and an allocation while full is dropped.
- R8: An entry shown on the issue port is freed at the next edge and issues exactly once.
- R9: A flush empties every entry at the next edge, and an allocation in the flush cycle is dropped.
- R10: A tag presented with `bc_valid`=0 wakes no operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Empty all entries |
| alloc_valid | input | 1 | Allocation request |
| alloc_opc | input | OPC_W | Opcode of the new instruction |
| alloc_src1_rdy | input | 1 | Source 1 flag: 1 = value, 0 = tag |
| alloc_src1 | input | DATA_W | Source 1 value, or producer tag in the low TAG_W bits |
| alloc_src2_rdy | input | 1 | Source 2 flag: 1 = value, 0 = tag |
| alloc_src2 | input | DATA_W | Source 2 value, or producer tag in the low TAG_W bits |
| alloc_dst_tag | input | TAG_W | Reorder-buffer tag of the result |
| bc_valid | input | 1 | Result broadcast present |
| bc_tag | input | TAG_W | Tag of the broadcast result |
| bc_data | input | DATA_W | Value of the broadcast result |
| full | output | 1 | Every entry occupied; front end must stall |
| issue_valid | output | 1 | An entry is issued this cycle |
| issue_opc | output | OPC_W | Issued opcode |
| issue_op1 | output | DATA_W | Issued source 1 value |
| issue_op2 | output | DATA_W | Issued source 2 value |
| issue_dst_tag | output | TAG_W | Issued destination tag |

## Verification
The bench builds the block with four entries, 3-bit tags, 8-bit data and 3-bit opcodes. With these values every tag can be swept on each source slot, with invalid, mismatching and matching broadcasts applied in turn. Four entries also make it cheap to fill the array, which brings the full stall and the dropped allocation within reach. Sharing tags across chosen entries makes several entries ready in the same cycle, which exposes both the grant order and which free entry an allocation lands in.

// File: rtl/rs_pkg.sv
// Package: shared default sizes for the reservation station array.
// Assumes DATA_W >= TAG_W, so a waiting operand keeps its tag in the low bits.
package rs_pkg;
    localparam int RS_DEF_ENTRIES = 4;
    localparam int RS_DEF_TAG_W   = 3;
    localparam int RS_DEF_DATA_W  = 8;
    localparam int RS_DEF_OPC_W   = 3;
endpackage

// File: rtl/rs_operand_slot.sv
// Module: one source operand of one entry.
// Holds a ready flag and a data field. When the flag is clear, the low TAG_W
// bits of the field are the producer tag. It snoops the broadcast bus while
// its entry is occupied. A load that coincides with a broadcast of its own tag
// takes the broadcast value.
module rs_operand_slot #(
    parameter int DATA_W = rs_pkg::RS_DEF_DATA_W,
    parameter int TAG_W  = rs_pkg::RS_DEF_TAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              load_rdy,
    input  logic [DATA_W-1:0] load_val,
    input  logic              snoop,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_data,
    output logic              rdy,
    output logic [DATA_W-1:0] val
);
    logic hit_new;
    logic hit_held;

    // Tag comparators: one for the incoming operand, one for the held operand.
    always_comb begin
        hit_new  = bc_valid && (load_val[TAG_W-1:0] == bc_tag);
        hit_held = bc_valid && (val[TAG_W-1:0] == bc_tag);
    end

    // Operand register: load, same-cycle capture, or later wakeup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy <= 1'b0;
            val <= '0;
        end else if (load) begin
            if (!load_rdy && hit_new) begin
                rdy <= 1'b1;
                val <= bc_data;
            end else begin
                rdy <= load_rdy;
                val <= load_val;
            end
        end else if (snoop && !rdy && hit_held) begin
            rdy <= 1'b1;
            val <= bc_data;
        end
    end
endmodule

// File: rtl/rs_select.sv
// Module: fixed-priority selector. The lowest set request bit wins.
// Gives a one-hot grant, its binary index and whether any request is set.
module rs_select #(
    parameter int N     = rs_pkg::RS_DEF_ENTRIES,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic [N-1:0]     oh,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    // Scan from entry 0 upward and keep the first request found.
    always_comb begin
        oh  = '0;
        idx = '0;
        any = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !any) begin
                oh[i] = 1'b1;
                idx   = IDX_W'(i);
                any   = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rs_station.sv
// Module: top of the reservation station array.
// It allocates into the lowest free entry and wakes operands from one
// broadcast bus. Each cycle it issues the lowest ready entry. The unit is
// assumed to accept every issue, so the granted entry frees at the next edge.
module rs_station #(
    parameter int ENTRIES = rs_pkg::RS_DEF_ENTRIES,
    parameter int TAG_W   = rs_pkg::RS_DEF_TAG_W,
    parameter int DATA_W  = rs_pkg::RS_DEF_DATA_W,
    parameter int OPC_W   = rs_pkg::RS_DEF_OPC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              alloc_valid,
    input  logic [OPC_W-1:0]  alloc_opc,
    input  logic              alloc_src1_rdy,
    input  logic [DATA_W-1:0] alloc_src1,
    input  logic              alloc_src2_rdy,
    input  logic [DATA_W-1:0] alloc_src2,
    input  logic [TAG_W-1:0]  alloc_dst_tag,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_data,
    output logic              full,
    output logic              issue_valid,
    output logic [OPC_W-1:0]  issue_opc,
    output logic [DATA_W-1:0] issue_op1,
    output logic [DATA_W-1:0] issue_op2,
    output logic [TAG_W-1:0]  issue_dst_tag
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0]        busy;
    logic [ENTRIES-1:0]        rdy1;
    logic [ENTRIES-1:0]        rdy2;
    logic [ENTRIES-1:0]        ready;
    logic [ENTRIES-1:0]        free_oh;
    logic [ENTRIES-1:0]        gnt_oh;
    logic [ENTRIES-1:0]        load_oh;
    logic [IDX_W-1:0]          free_idx;
    logic [IDX_W-1:0]          gnt_idx;
    logic                      free_any;
    logic [DATA_W-1:0]         val1 [ENTRIES];
    logic [DATA_W-1:0]         val2 [ENTRIES];
    logic [OPC_W-1:0]          opc_q [ENTRIES];
    logic [TAG_W-1:0]          dst_q [ENTRIES];
    logic [ENTRIES*DATA_W-1:0] v1_flat;
    logic [ENTRIES*DATA_W-1:0] v2_flat;

    // Free-entry selector: lowest unoccupied entry takes the next allocation.
    rs_select #(.N(ENTRIES)) u_free (
        .req(~busy), .oh(free_oh), .idx(free_idx), .any(free_any)
    );

    // Issue selector: lowest entry with both operands ready is granted.
    rs_select #(.N(ENTRIES)) u_gnt (
        .req(ready), .oh(gnt_oh), .idx(gnt_idx), .any(issue_valid)
    );

    // Allocation and readiness decode.
    always_comb begin
        full    = ~free_any;
        load_oh = (alloc_valid && !flush && free_any) ? free_oh : '0;
        ready   = busy & rdy1 & rdy2;
    end

    // Occupancy: flush empties, grant frees, allocation occupies.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            busy <= '0;
        end else begin
            busy <= (busy & ~gnt_oh) | load_oh;
        end
    end

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        // Opcode and destination tag: written only on allocation.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                opc_q[e] <= '0;
                dst_q[e] <= '0;
            end else if (load_oh[e]) begin
                opc_q[e] <= alloc_opc;
                dst_q[e] <= alloc_dst_tag;
            end
        end

        rs_operand_slot #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_src1 (
            .clk(clk), .rst_n(rst_n), .load(load_oh[e]),
            .load_rdy(alloc_src1_rdy), .load_val(alloc_src1),
            .snoop(busy[e]), .bc_valid(bc_valid), .bc_tag(bc_tag),
            .bc_data(bc_data), .rdy(rdy1[e]), .val(val1[e])
        );

        rs_operand_slot #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_src2 (
            .clk(clk), .rst_n(rst_n), .load(load_oh[e]),
            .load_rdy(alloc_src2_rdy), .load_val(alloc_src2),
            .snoop(busy[e]), .bc_valid(bc_valid), .bc_tag(bc_tag),
            .bc_data(bc_data), .rdy(rdy2[e]), .val(val2[e])
        );

        // Flattened operand views for the checker.
        assign v1_flat[e*DATA_W +: DATA_W] = val1[e];
        assign v2_flat[e*DATA_W +: DATA_W] = val2[e];
    end

    // Issue port: fields of the granted entry.
    always_comb begin
        issue_opc     = opc_q[gnt_idx];
        issue_op1     = val1[gnt_idx];
        issue_op2     = val2[gnt_idx];
        issue_dst_tag = dst_q[gnt_idx];
    end
endmodule

// File: rtl/rs_station_chk.sv
// Module: assertion checker for rs_station, attached with bind below.
// Watches occupancy, grants and operand flags through the top's internals.
module rs_station_chk #(
    parameter int ENTRIES = 4,
    parameter int TAG_W   = 3,
    parameter int DATA_W  = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      flush,
    input logic                      full,
    input logic                      issue_valid,
    input logic                      bc_valid,
    input logic [TAG_W-1:0]          bc_tag,
    input logic [DATA_W-1:0]         bc_data,
    input logic [ENTRIES-1:0]        busy,
    input logic [ENTRIES-1:0]        gnt_oh,
    input logic [ENTRIES-1:0]        rdy1,
    input logic [ENTRIES-1:0]        rdy2,
    input logic [ENTRIES*DATA_W-1:0] v1_flat,
    input logic [ENTRIES*DATA_W-1:0] v2_flat
);
    // R1: reset leaves the array empty.
    p_reset_empty_r1: assert property (@(posedge clk) !rst_n |=> (busy == '0));

    // R9: flush empties every entry.
    p_flush_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (busy == '0));

    // R7: while full, occupancy never grows.
    p_full_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> ($countones(busy) <= $countones($past(busy))));

    // R6: at most one entry is granted per cycle.
    p_one_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_oh));

    // R8: the granted entry is free after the next edge.
    p_grant_frees_r8: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |=> ((busy & $past(gnt_oh)) == '0));

    // R3: a granted entry has both operands ready.
    p_issue_ops_r3: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> ((gnt_oh & ~(rdy1 & rdy2)) == '0));

    for (genvar e = 0; e < ENTRIES; e++) begin : g_wake
        // R4: a held tag that matches the broadcast captures its value.
        p_wake1_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (bc_valid && busy[e] && !rdy1[e] &&
             v1_flat[e*DATA_W +: TAG_W] == bc_tag)
            |=> (rdy1[e] && v1_flat[e*DATA_W +: DATA_W] == $past(bc_data)));
        p_wake2_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (bc_valid && busy[e] && !rdy2[e] &&
             v2_flat[e*DATA_W +: TAG_W] == bc_tag)
            |=> (rdy2[e] && v2_flat[e*DATA_W +: DATA_W] == $past(bc_data)));
        // R10: no broadcast keeps a waiting occupied operand waiting.
        p_idle1_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (!bc_valid && busy[e] && !rdy1[e] && !flush) |=> !rdy1[e] || !busy[e] || $changed(v1_flat[e*DATA_W +: DATA_W]));
    end
endmodule

bind rs_station rs_station_chk #(
    .ENTRIES(ENTRIES), .TAG_W(TAG_W), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .flush(flush), .full(full),
    .issue_valid(issue_valid), .bc_valid(bc_valid), .bc_tag(bc_tag),
    .bc_data(bc_data), .busy(busy), .gnt_oh(gnt_oh), .rdy1(rdy1),
    .rdy2(rdy2), .v1_flat(v1_flat), .v2_flat(v2_flat)
);

// File: tb/sim_rs_station.sv
// Bench: directed sweeps over a four-entry array. Inputs change at the falling
// edge and outputs are sampled at the falling edge after each rising edge.
module sim_rs_station;
    localparam int ENTRIES = 4;
    localparam int TAG_W   = 3;
    localparam int DATA_W  = 8;
    localparam int OPC_W   = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              fl = 1'b0;
    logic              a_v = 1'b0;
    logic [OPC_W-1:0]  a_opc = '0;
    logic              a_r1 = 1'b0;
    logic [DATA_W-1:0] a_s1 = '0;
    logic              a_r2 = 1'b0;
    logic [DATA_W-1:0] a_s2 = '0;
    logic [TAG_W-1:0]  a_dst = '0;
    logic              b_v = 1'b0;
    logic [TAG_W-1:0]  b_tag = '0;
    logic [DATA_W-1:0] b_data = '0;
    logic              full;
    logic              iv;
    logic [OPC_W-1:0]  i_opc;
    logic [DATA_W-1:0] i_op1;
    logic [DATA_W-1:0] i_op2;
    logic [TAG_W-1:0]  i_dst;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rs_station #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .DATA_W(DATA_W), .OPC_W(OPC_W)) u0 (
        .clk(clk), .rst_n(rst_n), .flush(fl), .alloc_valid(a_v),
        .alloc_opc(a_opc), .alloc_src1_rdy(a_r1), .alloc_src1(a_s1),
        .alloc_src2_rdy(a_r2), .alloc_src2(a_s2), .alloc_dst_tag(a_dst),
        .bc_valid(b_v), .bc_tag(b_tag), .bc_data(b_data), .full(full),
        .issue_valid(iv), .issue_opc(i_opc), .issue_op1(i_op1),
        .issue_op2(i_op2), .issue_dst_tag(i_dst)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic set_alloc(input int opc, input bit r1, input int s1,
                             input bit r2, input int s2, input int dst);
        a_v = 1'b1; a_opc = OPC_W'(opc); a_r1 = r1; a_s1 = DATA_W'(s1);
        a_r2 = r2; a_s2 = DATA_W'(s2); a_dst = TAG_W'(dst);
    endtask

    task automatic idle();
        a_v = 1'b0; b_v = 1'b0; fl = 1'b0;
    endtask

    task automatic set_bc(input bit v, input int tag, input int data);
        b_v = v; b_tag = TAG_W'(tag); b_data = DATA_W'(data);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            finish_run();
        end
    end

    initial begin
        // R1: reset state.
        step(); step();
        chk("R1 full in reset", int'(full), 0);
        chk("R1 issue in reset", int'(iv), 0);
        rst_n = 1'b1;
        step();
        chk("R1 full after reset", int'(full), 0);
        chk("R1 issue after reset", int'(iv), 0);

        // R2: both operands ready at allocation.
        set_alloc(6, 1, 8'h3C, 1, 8'hC3, 5);
        step(); idle();
        chk("R2 issue_valid", int'(iv), 1);
        chk("R2 opc", int'(i_opc), 6);
        chk("R2 op1", int'(i_op1), 8'h3C);
        chk("R2 op2", int'(i_op2), 8'hC3);
        chk("R2 dst", int'(i_dst), 5);
        step();
        chk("R8 freed after issue", int'(iv), 0);

        // R3/R4/R10: sweep every tag on each source slot.
        for (int side = 0; side < 2; side++) begin
            for (int t = 0; t < 8; t++) begin
                int d;
                d = (t * 17 + 3) & 8'hFF;
                if (side == 0) set_alloc(t, 0, t, 1, 8'hC0 + t, t);
                else           set_alloc(t, 1, 8'hC0 + t, 0, t, t);
                step(); idle();
                chk("R3 waiting operand blocks issue", int'(iv), 0);
                set_bc(0, t, d);
                step();
                chk("R10 invalid broadcast ignored", int'(iv), 0);
                set_bc(1, (t + 1) % 8, d);
                step();
                chk("R4 mismatching tag ignored", int'(iv), 0);
                set_bc(1, t, d);
                step(); idle();
                chk("R4 wake issue_valid", int'(iv), 1);
                chk("R4 wake captured value", int'(side == 0 ? i_op1 : i_op2), d);
                chk("R4 wake kept other value", int'(side == 0 ? i_op2 : i_op1), 8'hC0 + t);
                chk("R4 wake dst", int'(i_dst), t);
                step();
                chk("R8 single issue", int'(iv), 0);
            end
        end

        // R7/R6/R4: fill with entries waiting on one tag, then wake all at once.
        for (int e = 0; e < ENTRIES; e++) begin
            set_alloc(e, 0, 5, 1, 8'hA0 + e, e);
            step();
        end
        idle();
        chk("R7 full when all occupied", int'(full), 1);
        set_alloc(7, 1, 8'h11, 1, 8'h22, 7);
        step(); idle();
        chk("R7 full after dropped alloc", int'(full), 1);
        chk("R7 dropped alloc not issued", int'(iv), 0);
        set_bc(1, 5, 8'h40);
        step(); idle();
        for (int e = 0; e < ENTRIES; e++) begin
            chk("R6 issue order valid", int'(iv), 1);
            chk("R6 issue order opc", int'(i_opc), e);
            chk("R4 shared tag op1", int'(i_op1), 8'h40);
            chk("R6 issue order op2", int'(i_op2), 8'hA0 + e);
            step();
        end
        chk("R8 drained", int'(iv), 0);
        chk("R7 not full after drain", int'(full), 0);

        // R6/R7: interleaved tags, then refill the lowest free entry.
        set_alloc(0, 0, 7, 1, 1, 0); step();
        set_alloc(1, 0, 6, 1, 1, 1); step();
        set_alloc(2, 0, 7, 1, 1, 2); step();
        set_alloc(3, 0, 6, 1, 1, 3); step();
        idle();
        set_bc(1, 6, 8'h66);
        step(); idle();
        chk("R6 lowest of 1,3", int'(i_opc), 1);
        step();
        chk("R6 next of 1,3", int'(i_opc), 3);
        step();
        chk("R3 tag-7 entries still wait", int'(iv), 0);
        chk("R7 not full with two free", int'(full), 0);
        set_alloc(5, 0, 7, 1, 1, 5);
        step(); idle();
        set_bc(1, 7, 8'h77);
        step(); idle();
        chk("R7 refill order first", int'(i_opc), 0);
        step();
        chk("R7 refill lands in entry 1", int'(i_opc), 5);
        step();
        chk("R7 refill order last", int'(i_opc), 2);
        chk("R4 tag-7 value", int'(i_op1), 8'h77);
        step();
        chk("R8 interleave drained", int'(iv), 0);

        // R5: allocation in the same cycle as a matching broadcast.
        set_alloc(4, 0, 2, 0, 2, 4);
        set_bc(1, 2, 8'h99);
        step(); idle();
        chk("R5 same-cycle issue", int'(iv), 1);
        chk("R5 same-cycle op1", int'(i_op1), 8'h99);
        chk("R5 same-cycle op2", int'(i_op2), 8'h99);
        step();
        set_alloc(4, 0, 2, 1, 8'h01, 4);
        set_bc(1, 3, 8'h99);
        step(); idle();
        chk("R5 same-cycle mismatch waits", int'(iv), 0);
        set_bc(1, 2, 8'h55);
        step(); idle();
        chk("R5 later wake op1", int'(i_op1), 8'h55);
        step();

        // R9: flush empties and drops a same-cycle allocation.
        set_alloc(1, 0, 1, 1, 0, 1); step();
        set_alloc(2, 0, 1, 1, 0, 2); step();
        set_alloc(3, 1, 8'h12, 1, 8'h34, 3);
        fl = 1'b1;
        step(); idle();
        chk("R9 flush clears full", int'(full), 0);
        chk("R9 flush drops alloc", int'(iv), 0);
        set_bc(1, 1, 8'hEE);
        step(); idle();
        chk("R9 flushed entries stay gone", int'(iv), 0);
        set_alloc(2, 1, 8'h21, 1, 8'h43, 6);
        step(); idle();
        chk("R9 usable after flush", int'(i_op2), 8'h43);
        step();

        finish_run();
    end
endmodule